// File: doc/BRIEF.md
# Fetch Target Queue

This block sits between a branch predictor and an instruction-cache fetch stage and lets the two run decoupled. Each cycle the predictor may push one predicted fetch block. A fetch block is a run of instructions that begins at a branch target and ends at a strongly biased branch. Each queue entry holds the block's start address, a short fall-through offset (5 bits by default) and a flag. The flag is set when the block spans more than one cache line, so a cache with several ports can fetch pieces of it in parallel. The fetch stage pops entries whenever it is ready. Its latency may differ from the predictor's, and sustained flow only needs the two rates to match.

The queue reports its fill level together with empty and full flags. A redirect input drops every queued block in a single cycle after a mispredict. Two free-running counters record how many cycles the queue spent empty and how many it spent full, so throughput balance can be measured.

Top module: `ftq_top`

## Requirements
- R1: After reset the queue is empty: `empty_o`=1, `full_o`=0, `level_o`=0, `deq_valid_o`=0, `enq_ready_o`=1, and both cycle counters read 0.
- R2: A push is accepted on a clock edge exactly when `enq_valid_i`=1, `enq_ready_o`=1 and `redirect_i`=0. `enq_ready_o` is low only while the queue is full.
- R3: Blocks leave in the order they entered. The head entry appears on `deq_addr_o`, `deq_off_o` and `deq_big_o` while `deq_valid_o`=1. The address, the 5-bit offset and the oversize flag come out bit-exact.
- R4: `full_o` is 1 exactly when `level_o` equals DEPTH. A push offered while full is dropped, and the stored entries stay unchanged.
- R5: `deq_valid_o` is 0 while the queue is empty. Asserting `deq_ready_i` then has no effect on the level or on later data.
- R6: A push and a pop on the same edge leave the level unchanged when the queue is neither empty nor full. When full, only the pop takes effect. When empty, only the push takes effect.
- R7: With `redirect_i`=1 on an edge the queue is empty after that edge. Any push or pop offered in the same cycle is ignored.
- R8: `level_o` always equals the number of blocks held (0..DEPTH), and `empty_o` and `full_o` are never both 1.
- R9: On every edge outside reset, `empty_cycles_o` increments when `empty_o` was 1 before the edge, and `full_cycles_o` increments when `full_o` was 1. Neither counter is cleared by a redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| redirect_i | input | 1 | Drop all queued blocks |
| enq_valid_i | input | 1 | Predictor offers a block |
| enq_ready_o | output | 1 | Queue can accept a block |
| enq_addr_i | input | ADDR_W | Block start address |
| enq_off_i | input | OFF_W | Fall-through offset |
| enq_big_i | input | 1 | Block exceeds one cache line |
| deq_valid_o | output | 1 | Head block is present |
| deq_ready_i | input | 1 | Fetch stage takes the head block |
| deq_addr_o | output | ADDR_W | Head start address |
| deq_off_o | output | OFF_W | Head fall-through offset |
| deq_big_o | output | 1 | Head oversize flag |
| empty_o | output | 1 | No blocks held |
| full_o | output | 1 | DEPTH blocks held |
| level_o | output | $clog2(DEPTH+1) | Blocks held |
| empty_cycles_o | output | CNT_W | Cycles spent empty |
| full_cycles_o | output | CNT_W | Cycles spent full |

## Verification
All outputs come from registers, so every effect of a push, pop or redirect is visible one edge after the cycle that offered it. The bench drives inputs on the falling edge, updates its reference queue on the rising edge, and compares on the next falling edge. A pushed block can therefore be popped on the very next cycle, with no bypass. Each counter reflects the flag value from before the edge, which the reference model reproduces by sampling its own occupancy before applying the cycle's operations.

// File: rtl/ftq_pkg.sv
package ftq_pkg;

    typedef enum logic [1:0] {
        OP_HOLD = 2'b00,
        OP_PUSH = 2'b01,
        OP_POP  = 2'b10,
        OP_SWAP = 2'b11
    } ftq_op_e;

    function automatic ftq_op_e ftq_decode(input logic push, input logic pop);
        return ftq_op_e'({pop, push});
    endfunction

endpackage

// File: rtl/ftq_ptrs.sv
module ftq_ptrs #(
    parameter int DEPTH = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             redirect_i,
    input  logic             enq_valid_i,
    input  logic             deq_ready_i,
    output logic             push_o,
    output logic [PTR_W-1:0] wr_idx_o,
    output logic [PTR_W-1:0] rd_idx_o,
    output logic [LVL_W-1:0] level_o,
    output logic             empty_o,
    output logic             full_o
);
    import ftq_pkg::*;

    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [LVL_W-1:0] cnt;
    } ptr_state_t;

    ptr_state_t st_d, st_q;
    logic       pop;
    ftq_op_e    op;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    assign empty_o  = (st_q.cnt == '0);
    assign full_o   = (st_q.cnt == LVL_W'(DEPTH));
    assign push_o   = enq_valid_i && !full_o && !redirect_i;
    assign pop      = deq_ready_i && !empty_o && !redirect_i;
    assign op       = ftq_decode(push_o, pop);
    assign wr_idx_o = st_q.wr;
    assign rd_idx_o = st_q.rd;
    assign level_o  = st_q.cnt;

    always_comb begin
        st_d = st_q;
        if (redirect_i) begin
            st_d = '0;
        end else begin
            unique case (op)
                OP_PUSH: begin
                    st_d.wr  = bump(st_q.wr);
                    st_d.cnt = st_q.cnt + LVL_W'(1);
                end
                OP_POP: begin
                    st_d.rd  = bump(st_q.rd);
                    st_d.cnt = st_q.cnt - LVL_W'(1);
                end
                OP_SWAP: begin
                    st_d.wr = bump(st_q.wr);
                    st_d.rd = bump(st_q.rd);
                end
                default: st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_level_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (level_o <= LVL_W'(DEPTH)) && !(empty_o && full_o));

    assert_redirect_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_i |=> (level_o == '0));

    assert_level_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(redirect_i) |-> (level_o == $past(level_o) ||
                                level_o == $past(level_o) + LVL_W'(1) ||
                                level_o + LVL_W'(1) == $past(level_o)));

    assert_no_overfill_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && !deq_ready_i) |=> full_o || $past(redirect_i));

    assert_empty_pop_noop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (empty_o && !enq_valid_i) |=> empty_o);

endmodule

// File: rtl/ftq_store.sv
module ftq_store #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 38,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [PTR_W-1:0] wr_idx_i,
    input  logic [WIDTH-1:0] wdata_i,
    input  logic [PTR_W-1:0] rd_idx_i,
    output logic [WIDTH-1:0] rdata_o
);
    logic [WIDTH-1:0] mem_d [DEPTH];
    logic [WIDTH-1:0] mem_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = (we_i && wr_idx_i == PTR_W'(i)) ? wdata_i : mem_q[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
        end
    end

    assign rdata_o = mem_q[rd_idx_i];

endmodule

// File: rtl/ftq_stats.sv
module ftq_stats #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             empty_i,
    input  logic             full_i,
    output logic [CNT_W-1:0] empty_cycles_o,
    output logic [CNT_W-1:0] full_cycles_o
);
    typedef struct packed {
        logic [CNT_W-1:0] emp;
        logic [CNT_W-1:0] ful;
    } stat_t;

    stat_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (empty_i) st_d.emp = st_q.emp + CNT_W'(1);
        if (full_i)  st_d.ful = st_q.ful + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign empty_cycles_o = st_q.emp;
    assign full_cycles_o  = st_q.ful;

    assert_empty_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (empty_cycles_o != $past(empty_cycles_o)) |-> $past(empty_i));

    assert_full_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (full_cycles_o != $past(full_cycles_o)) |-> $past(full_i));

endmodule

// File: rtl/ftq_top.sv
module ftq_top #(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 5,
    parameter int CNT_W  = 32,
    localparam int ENT_W = ADDR_W + OFF_W + 1,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              redirect_i,
    input  logic              enq_valid_i,
    output logic              enq_ready_o,
    input  logic [ADDR_W-1:0] enq_addr_i,
    input  logic [OFF_W-1:0]  enq_off_i,
    input  logic              enq_big_i,
    output logic              deq_valid_o,
    input  logic              deq_ready_i,
    output logic [ADDR_W-1:0] deq_addr_o,
    output logic [OFF_W-1:0]  deq_off_o,
    output logic              deq_big_o,
    output logic              empty_o,
    output logic              full_o,
    output logic [LVL_W-1:0]  level_o,
    output logic [CNT_W-1:0]  empty_cycles_o,
    output logic [CNT_W-1:0]  full_cycles_o
);
    logic             push;
    logic [PTR_W-1:0] wr_idx, rd_idx;
    logic [ENT_W-1:0] head;

    ftq_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk        (clk),
        .rst_n      (rst_n),
        .redirect_i (redirect_i),
        .enq_valid_i(enq_valid_i),
        .deq_ready_i(deq_ready_i),
        .push_o     (push),
        .wr_idx_o   (wr_idx),
        .rd_idx_o   (rd_idx),
        .level_o    (level_o),
        .empty_o    (empty_o),
        .full_o     (full_o)
    );

    ftq_store #(.DEPTH(DEPTH), .WIDTH(ENT_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (push),
        .wr_idx_i(wr_idx),
        .wdata_i ({enq_addr_i, enq_off_i, enq_big_i}),
        .rd_idx_i(rd_idx),
        .rdata_o (head)
    );

    ftq_stats #(.CNT_W(CNT_W)) u_stats (
        .clk           (clk),
        .rst_n         (rst_n),
        .empty_i       (empty_o),
        .full_i        (full_o),
        .empty_cycles_o(empty_cycles_o),
        .full_cycles_o (full_cycles_o)
    );

    assign enq_ready_o = !full_o;
    assign deq_valid_o = !empty_o;
    assign {deq_addr_o, deq_off_o, deq_big_o} = head;

    assert_push_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (enq_valid_i && !enq_ready_o && !deq_ready_i && !redirect_i) |=> $stable(level_o));

endmodule

// File: tb/ftq_top_tb.sv
module ftq_top_tb;
    localparam int DEPTH  = 8;
    localparam int ADDR_W = 32;
    localparam int OFF_W  = 5;
    localparam int CNT_W  = 32;
    localparam int LVL_W  = $clog2(DEPTH + 1);
    localparam int ENT_W  = ADDR_W + OFF_W + 1;

    logic clk = 0;
    logic rst_n = 0;
    logic redirect = 0, enq_valid = 0, deq_ready = 0, enq_big = 0;
    logic [ADDR_W-1:0] enq_addr = '0;
    logic [OFF_W-1:0]  enq_off = '0;
    logic enq_ready, deq_valid, deq_big, empty, full;
    logic [ADDR_W-1:0] deq_addr;
    logic [OFF_W-1:0]  deq_off;
    logic [LVL_W-1:0]  level;
    logic [CNT_W-1:0]  emp_cyc, ful_cyc;

    int checks = 0, fails = 0;
    logic [ENT_W-1:0] mq[$];
    int m_emp = 0, m_ful = 0;

    always #5 clk = ~clk;

    ftq_top #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .OFF_W(OFF_W), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .redirect_i(redirect),
        .enq_valid_i(enq_valid), .enq_ready_o(enq_ready),
        .enq_addr_i(enq_addr), .enq_off_i(enq_off), .enq_big_i(enq_big),
        .deq_valid_o(deq_valid), .deq_ready_i(deq_ready),
        .deq_addr_o(deq_addr), .deq_off_o(deq_off), .deq_big_o(deq_big),
        .empty_o(empty), .full_o(full), .level_o(level),
        .empty_cycles_o(emp_cyc), .full_cycles_o(ful_cyc)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare(input string tag);
        int n = mq.size();
        chk(level == LVL_W'(n), {tag, " R8 level"}, 64'(level), 64'(n));
        chk(empty == (n == 0), {tag, " R5 empty"}, 64'(empty), 64'(n == 0));
        chk(deq_valid == (n != 0), {tag, " R5 deq_valid"}, 64'(deq_valid), 64'(n != 0));
        chk(full == (n == DEPTH), {tag, " R4 full"}, 64'(full), 64'(n == DEPTH));
        chk(enq_ready == (n != DEPTH), {tag, " R2 enq_ready"}, 64'(enq_ready), 64'(n != DEPTH));
        if (n != 0)
            chk({deq_addr, deq_off, deq_big} == mq[0], {tag, " R3 head"},
                64'({deq_addr, deq_off, deq_big}), 64'(mq[0]));
        chk(emp_cyc == CNT_W'(m_emp), {tag, " R9 empty_cycles"}, 64'(emp_cyc), 64'(m_emp));
        chk(ful_cyc == CNT_W'(m_ful), {tag, " R9 full_cycles"}, 64'(ful_cyc), 64'(m_ful));
    endtask

    // Drive at falling edge, model at rising edge, compare at next falling edge.
    task automatic tick(input logic ev, input logic dr, input logic fl, input string tag);
        enq_valid = ev; deq_ready = dr; redirect = fl;
        enq_addr = $urandom; enq_off = OFF_W'($urandom); enq_big = 1'($urandom);
        @(posedge clk);
        begin
            int n = mq.size();
            logic [ENT_W-1:0] e = {enq_addr, enq_off, enq_big};
            if (n == 0) m_emp++;
            if (n == DEPTH) m_ful++;
            if (fl) mq.delete();
            else begin
                if (dr && n > 0) void'(mq.pop_front());
                if (ev && n < DEPTH) mq.push_back(e);
            end
        end
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        #2000000;
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        compare("R1 reset");
        rst_n = 1;
        // R1: idle after reset, empty counter runs
        tick(0, 0, 0, "R1 idle");
        // R5: pop on empty ignored
        tick(0, 1, 0, "R5 pop empty");
        tick(0, 1, 0, "R5 pop empty");
        // R6: push and pop together on empty -> only push
        tick(1, 1, 0, "R6 swap empty");
        // fill to full (R2, R4)
        for (int i = 0; i < DEPTH + 2; i++) tick(1, 0, 0, "R4 fill");
        // R4: push while full ignored, stays full
        tick(1, 0, 0, "R4 push full");
        tick(1, 0, 0, "R4 push full");
        // R6: push and pop together on full -> only pop
        tick(1, 1, 0, "R6 swap full");
        // R6: steady swap mid-level
        for (int i = 0; i < 6; i++) tick(1, 1, 0, "R6 swap mid");
        // R3: drain in order
        for (int i = 0; i < DEPTH + 1; i++) tick(0, 1, 0, "R3 drain");
        // R7: redirect with push and pop offered
        for (int i = 0; i < 5; i++) tick(1, 0, 0, "R7 refill");
        tick(1, 1, 1, "R7 redirect");
        tick(0, 1, 0, "R7 after redirect");
        // R7: redirect while full
        for (int i = 0; i < DEPTH; i++) tick(1, 0, 0, "R7 fill");
        tick(1, 0, 1, "R7 redirect full");
        // mixed traffic
        for (int i = 0; i < 400; i++)
            tick(1'($urandom % 4 != 0), 1'($urandom % 3 != 0), 1'($urandom % 41 == 0), "R3 mixed");
        for (int i = 0; i < 300; i++)
            tick(1'($urandom % 5 != 0), 1'($urandom % 4 == 0), 1'($urandom % 97 == 0), "R9 bias full");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule